// File: doc/BRIEF.md
# Open-Page DRAM Command Scheduler with Ready-First Ranking

This block buffers pending read requests for one DRAM channel and turns them into a stream of precharge, activate and column-read commands. Each request carries a bank, a row and a column. The block remembers which row, if any, is open in every bank. It keeps a row open until a queued request needs a different row in that same bank.

Each cycle the block looks at every queued request. It works out the next command that request needs, given the state of its bank, and picks at most one command to issue. A request can only be picked if its bank is idle. Among the requests that can go, column reads win over row commands, and after that the request that has waited longest wins. A request leaves the buffer on the cycle its column read issues.

Per-bank timing is modelled by a down-counter. Each command type loads its own fixed latency into the counter, and the bank accepts a new command only once the counter has run out.

Top module: `dsched_frfcfs`

## Requirements
- R1: A request whose bank is busy never issues. While it waits, a request to an idle bank issues, even if that request is younger.
- R2: When a column read and a row command (precharge or activate) could both issue in the same cycle, the column read issues.
- R3: When two candidates that could issue are the same kind (both column or both row), the one accepted earlier issues first.
- R4: A request to the row that is open in its bank produces a single column read (cmd_type 3). No precharge of that row issues while no other row is requested in that bank.
- R5: A request to a bank with no open row produces an activate (cmd_type 2) carrying its row, followed by a column read (cmd_type 3) carrying its column.
- R6: A request to a bank whose open row differs produces, in order, a precharge (cmd_type 1), an activate of the new row and a column read.
- R7: After a command to a bank, that bank takes no further command for the command's latency in cycles: PRE_LAT for a precharge, ACT_LAT for an activate, RD_LAT for a read. A command that is waiting issues exactly that many cycles later.
- R8: At most one command issues per cycle, and cmd_type is 0 whenever cmd_valid is low. A request is removed from the buffer when its column read issues.
- R9: While all DEPTH slots are occupied, req_ready is low. A request held on the input is accepted once a column read frees a slot, and it keeps its place in age order.
- R10: After reset the buffer is empty, every bank is closed, cmd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | A buffer slot is free |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| cmd_valid | output | 1 | A command issues at the next clock edge |
| cmd_type | output | 2 | 0 none, 1 precharge, 2 activate, 3 column read |
| cmd_bank | output | BANK_W | Target bank of the command |
| cmd_row | output | ROW_W | Row of the chosen request |
| cmd_col | output | COL_W | Column of the chosen request |

## Verification
The hardest situation to reach is one where several requests could issue in the same cycle, because any ready request issues the cycle after it arrives. The stimulus first sends a request that opens a bank. It then uses the activate latency as a window and queues further requests behind it during that window: an older conflicting request and a younger row hit to the same bank, or a busy-bank hit and a request to a closed idle bank. When the window ends, the ranking rules alone decide the order. Filling the buffer uses the same idea: a precharge and an activate hold the bank while four requests arrive.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

    parameter int BANKS = 4;
    parameter int ROW_W = 8;
    parameter int COL_W = 6;
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PRE  = 2'd1,
        CMD_ACT  = 2'd2,
        CMD_RD   = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } dreq_t;

    // Next command a request needs, given its bank's row state.
    function automatic cmd_e next_cmd(input logic is_open,
                                      input logic [ROW_W-1:0] open_row,
                                      input logic [ROW_W-1:0] want_row);
        if (!is_open)
            return CMD_ACT;
        else if (open_row == want_row)
            return CMD_RD;
        else
            return CMD_PRE;
    endfunction

endpackage

// File: rtl/dsched_queue.sv
module dsched_queue
    import dsched_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  dreq_t            push_req,
    input  logic [DEPTH-1:0] pop_oh,
    output logic [DEPTH-1:0] slot_used,
    output dreq_t            slot_req [DEPTH],
    output logic [AGE_W-1:0] slot_age [DEPTH],
    output logic             full
);

    logic [DEPTH-1:0] ins_oh;
    logic             found;

    always_comb begin
        ins_oh = '0;
        found  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!slot_used[i] && !found) begin
                ins_oh[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    assign full = &slot_used;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_used <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_req[i] <= '0;
                slot_age[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (pop_oh[i]) begin
                    slot_used[i] <= 1'b0;
                end else if (slot_used[i]) begin
                    if (slot_age[i] != '1)
                        slot_age[i] <= slot_age[i] + 1'b1;
                end else if (push && ins_oh[i]) begin
                    slot_used[i] <= 1'b1;
                    slot_req[i]  <= push_req;
                    slot_age[i]  <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/dsched_banks.sv
module dsched_banks
    import dsched_pkg::*;
#(
    parameter int PRE_LAT = 3,
    parameter int ACT_LAT = 4,
    parameter int RD_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  cmd_e              issue_cmd,
    input  logic [BANK_W-1:0] issue_bank,
    input  logic [ROW_W-1:0]  issue_row,
    output logic              bank_open [BANKS],
    output logic [ROW_W-1:0]  bank_row  [BANKS],
    output logic              bank_idle [BANKS]
);

    localparam int MAX_LAT = (PRE_LAT > ACT_LAT) ?
                             ((PRE_LAT > RD_LAT) ? PRE_LAT : RD_LAT) :
                             ((ACT_LAT > RD_LAT) ? ACT_LAT : RD_LAT);
    localparam int CNT_W = $clog2(MAX_LAT + 1);

    logic [CNT_W-1:0] cnt_q [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_idle[b] = (cnt_q[b] == '0);

        always_ff @(posedge clk) begin
            if (rst) begin
                bank_open[b] <= 1'b0;
                bank_row[b]  <= '0;
                cnt_q[b]     <= '0;
            end else if (issue && issue_bank == BANK_W'(b)) begin
                case (issue_cmd)
                    CMD_PRE: begin
                        bank_open[b] <= 1'b0;
                        cnt_q[b]     <= CNT_W'(PRE_LAT - 1);
                    end
                    CMD_ACT: begin
                        bank_open[b] <= 1'b1;
                        bank_row[b]  <= issue_row;
                        cnt_q[b]     <= CNT_W'(ACT_LAT - 1);
                    end
                    CMD_RD:  cnt_q[b] <= CNT_W'(RD_LAT - 1);
                    default: cnt_q[b] <= cnt_q[b];
                endcase
            end else if (cnt_q[b] != '0) begin
                cnt_q[b] <= cnt_q[b] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsched_pick.sv
module dsched_pick
    import dsched_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AGE_W = 8
) (
    input  logic             slot_used [DEPTH],
    input  dreq_t            slot_req  [DEPTH],
    input  logic [AGE_W-1:0] slot_age  [DEPTH],
    input  logic             bank_open [BANKS],
    input  logic [ROW_W-1:0] bank_row  [BANKS],
    input  logic             bank_idle [BANKS],
    output logic [DEPTH-1:0] grant_oh,
    output logic             win_valid,
    output cmd_e             win_cmd,
    output dreq_t            win_req
);

    // Rank key: column flag above age; only ready slots compete.
    logic [AGE_W:0]    best_key;
    logic [AGE_W:0]    key;
    cmd_e              cand;
    logic [BANK_W-1:0] b;

    always_comb begin
        grant_oh  = '0;
        win_valid = 1'b0;
        win_cmd   = CMD_NONE;
        win_req   = '0;
        best_key  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            b    = slot_req[i].bank;
            cand = next_cmd(bank_open[b], bank_row[b], slot_req[i].row);
            key  = {(cand == CMD_RD), slot_age[i]};
            if (slot_used[i] && bank_idle[b] && (!win_valid || key > best_key)) begin
                win_valid = 1'b1;
                best_key  = key;
                win_cmd   = cand;
                win_req   = slot_req[i];
                grant_oh  = '0;
                grant_oh[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsched_frfcfs.sv
module dsched_frfcfs
    import dsched_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int AGE_W   = 8,
    parameter int PRE_LAT = 3,
    parameter int ACT_LAT = 4,
    parameter int RD_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              cmd_valid,
    output logic [1:0]        cmd_type,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col
);

    logic [DEPTH-1:0] used_vec;
    logic             used_arr [DEPTH];
    dreq_t            slot_req [DEPTH];
    logic [AGE_W-1:0] slot_age [DEPTH];
    logic             full;
    logic             bank_open [BANKS];
    logic [ROW_W-1:0] bank_row  [BANKS];
    logic             bank_idle [BANKS];
    logic [DEPTH-1:0] grant_oh;
    logic             win_valid;
    cmd_e             win_cmd;
    dreq_t            win_req;
    dreq_t            in_req;

    assign in_req    = '{bank: req_bank, row: req_row, col: req_col};
    assign req_ready = !full;

    for (genvar i = 0; i < DEPTH; i++) begin : g_used
        assign used_arr[i] = used_vec[i];
    end

    dsched_queue #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (req_valid && !full),
        .push_req  (in_req),
        .pop_oh    (grant_oh & {DEPTH{win_cmd == CMD_RD}}),
        .slot_used (used_vec),
        .slot_req  (slot_req),
        .slot_age  (slot_age),
        .full      (full)
    );

    dsched_banks #(.PRE_LAT(PRE_LAT), .ACT_LAT(ACT_LAT), .RD_LAT(RD_LAT)) u_banks (
        .clk        (clk),
        .rst        (rst),
        .issue      (win_valid),
        .issue_cmd  (win_cmd),
        .issue_bank (win_req.bank),
        .issue_row  (win_req.row),
        .bank_open  (bank_open),
        .bank_row   (bank_row),
        .bank_idle  (bank_idle)
    );

    dsched_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_pick (
        .slot_used (used_arr),
        .slot_req  (slot_req),
        .slot_age  (slot_age),
        .bank_open (bank_open),
        .bank_row  (bank_row),
        .bank_idle (bank_idle),
        .grant_oh  (grant_oh),
        .win_valid (win_valid),
        .win_cmd   (win_cmd),
        .win_req   (win_req)
    );

    assign cmd_valid = win_valid;
    assign cmd_type  = win_cmd;
    assign cmd_bank  = win_req.bank;
    assign cmd_row   = win_req.row;
    assign cmd_col   = win_req.col;

endmodule

// File: rtl/dsched_frfcfs_chk.sv
module dsched_frfcfs_chk
    import dsched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic [1:0]        cmd_type,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ROW_W-1:0]  cmd_row
);

    localparam int OCC_W = $clog2(DEPTH + 1) + 1;

    // Independent shadow of bank state and buffer occupancy, built from ports.
    logic [1:0]       last_q [BANKS];
    logic [ROW_W-1:0] row_q  [BANKS];
    logic [OCC_W-1:0] occ_q;
    logic             acc;
    logic             leave;

    assign acc   = req_valid && req_ready;
    assign leave = cmd_valid && cmd_type == 2'd3;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
            for (int b = 0; b < BANKS; b++) begin
                last_q[b] <= 2'd0;
                row_q[b]  <= '0;
            end
        end else begin
            occ_q <= occ_q + OCC_W'(acc) - OCC_W'(leave);
            if (cmd_valid) begin
                last_q[cmd_bank] <= cmd_type;
                if (cmd_type == 2'd2)
                    row_q[cmd_bank] <= cmd_row;
            end
        end
    end

    a_r5_act_on_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_type == 2'd2) |->
            (last_q[cmd_bank] == 2'd0 || last_q[cmd_bank] == 2'd1));

    a_r6_pre_on_open: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_type == 2'd1) |->
            (last_q[cmd_bank] == 2'd2 || last_q[cmd_bank] == 2'd3));

    a_r4_read_open_row: assert property (@(posedge clk) disable iff (rst)
        leave |-> ((last_q[cmd_bank] == 2'd2 || last_q[cmd_bank] == 2'd3)
                   && row_q[cmd_bank] == cmd_row));

    a_r6_pre_other_row: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_type == 2'd1) |-> (row_q[cmd_bank] != cmd_row));

    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !(cmd_valid && cmd_bank == $past(cmd_bank)));

    a_r8_none_when_idle: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> cmd_type == 2'd0);

    a_r9_ready_full: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> occ_q == OCC_W'(DEPTH));

    a_r9_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ_q <= OCC_W'(DEPTH));

    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!cmd_valid && req_ready));

endmodule

bind dsched_frfcfs dsched_frfcfs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .cmd_bank  (cmd_bank),
    .cmd_row   (cmd_row)
);

// File: tb/dsched_frfcfs_bench.sv
`timescale 1ns/1ps
module dsched_frfcfs_bench;
    import dsched_pkg::*;

    localparam int T_PRE = 1, T_ACT = 2, T_RD = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              cmd_valid;
    logic [1:0]        cmd_type;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int lg_n = 0;
    int lg_type [64];
    int lg_bank [64];
    int lg_row  [64];
    int lg_col  [64];
    int lg_cyc  [64];
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsched_frfcfs u_dsched_frfcfs (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Record each command that will issue at the coming edge.
    always @(negedge clk) begin
        if (!rst && cmd_valid && lg_n < 64) begin
            lg_type[lg_n] = cmd_type;
            lg_bank[lg_n] = cmd_bank;
            lg_row[lg_n]  = cmd_row;
            lg_col[lg_n]  = cmd_col;
            lg_cyc[lg_n]  = cyc;
            lg_n = lg_n + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One check: the k-th logged command has the given type, bank and operand.
    task automatic expect_cmd(input string tag, input int k, input int t,
                              input int b, input int val);
        int got;
        checks++;
        if (k >= lg_n) begin
            errors++;
            $display("FAIL %s: actual=missing cmd %0d expected=type %0d", tag, k, t);
        end else begin
            got = (t == T_RD) ? lg_col[k] : lg_row[k];
            if (lg_type[k] != t || lg_bank[k] != b || got != val) begin
                errors++;
                $display("FAIL %s: actual=t%0d b%0d v%0d expected=t%0d b%0d v%0d",
                         tag, lg_type[k], lg_bank[k], got, t, b, val);
            end
        end
    endtask

    // Called at a negedge; returns at the negedge after acceptance.
    task automatic send(input int b, input int r, input int c, output int waited);
        waited = 0;
        req_valid = 1'b1;
        req_bank  = BANK_W'(b);
        req_row   = ROW_W'(r);
        req_col   = COL_W'(c);
        while (!req_ready) begin
            waited++;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 cmd_valid after reset", cmd_valid, 0);
        chk("R10 req_ready after reset", req_ready, 1);
        chk("R8 cmd_type when idle", cmd_type, 0);
    endtask

    task automatic t_closed_bank();
        int base = lg_n;
        int w;
        send(0, 5, 1, w);
        idle(12);
        expect_cmd("R5 activate on closed bank", base, T_ACT, 0, 5);
        expect_cmd("R5 read after activate", base + 1, T_RD, 0, 1);
        chk("R7 activate-to-read spacing", lg_cyc[base + 1] - lg_cyc[base], 4);
        chk("R8 command count closed bank", lg_n - base, 2);
    endtask

    task automatic t_row_hit();
        int base = lg_n;
        int w;
        send(0, 5, 2, w);
        idle(10);
        expect_cmd("R4 hit gives read only", base, T_RD, 0, 2);
        chk("R4 no extra command on hit", lg_n - base, 1);
    endtask

    task automatic t_conflict();
        int base = lg_n;
        int w;
        send(0, 9, 3, w);
        idle(15);
        expect_cmd("R6 precharge first", base, T_PRE, 0, 9);
        expect_cmd("R6 activate new row", base + 1, T_ACT, 0, 9);
        expect_cmd("R6 read last", base + 2, T_RD, 0, 3);
        chk("R7 precharge-to-activate spacing", lg_cyc[base + 1] - lg_cyc[base], 3);
        chk("R6 command count conflict", lg_n - base, 3);
    endtask

    // Older conflict and younger hit queue behind an activate of bank 1.
    task automatic t_column_first();
        int base = lg_n;
        int w;
        send(1, 2, 10, w);
        send(1, 3, 11, w);
        send(1, 2, 12, w);
        idle(25);
        expect_cmd("R5 activate bank1", base, T_ACT, 1, 2);
        expect_cmd("R3 older read first", base + 1, T_RD, 1, 10);
        expect_cmd("R2 younger hit beats older precharge", base + 2, T_RD, 1, 12);
        expect_cmd("R6 precharge after hits", base + 3, T_PRE, 1, 3);
        expect_cmd("R6 activate row3", base + 4, T_ACT, 1, 3);
        expect_cmd("R6 read row3", base + 5, T_RD, 1, 11);
    endtask

    // A busy-bank hit waits while a younger request to idle bank 3 issues.
    task automatic t_ready_first();
        int base = lg_n;
        int w;
        send(2, 1, 20, w);
        send(2, 1, 21, w);
        send(3, 4, 22, w);
        idle(25);
        expect_cmd("R5 activate bank2", base, T_ACT, 2, 1);
        expect_cmd("R1 idle bank3 goes ahead", base + 1, T_ACT, 3, 4);
        expect_cmd("R3 bank2 first read", base + 2, T_RD, 2, 20);
        expect_cmd("R3 bank2 second read", base + 3, T_RD, 2, 21);
        expect_cmd("R1 bank3 read", base + 4, T_RD, 3, 22);
    endtask

    task automatic t_full();
        int base = lg_n;
        int w;
        send(2, 7, 30, w);
        send(2, 7, 31, w);
        send(2, 7, 32, w);
        send(2, 7, 33, w);
        chk("R9 ready low when full", req_ready, 0);
        send(2, 7, 34, w);
        chk("R9 held request waits for a read", w, 5);
        idle(30);
        expect_cmd("R6 precharge bank2", base, T_PRE, 2, 7);
        expect_cmd("R6 activate bank2 row7", base + 1, T_ACT, 2, 7);
        for (int k = 0; k < 5; k++)
            expect_cmd("R3 reads in arrival order", base + 2 + k, T_RD, 2, 30 + k);
        chk("R8 all requests drained", lg_n - base, 7);
        chk("R9 ready back after drain", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_closed_bank();
        t_row_hit();
        t_conflict();
        t_column_first();
        t_ready_first();
        t_full();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule